// File: doc/BRIEF.md
# Output and Reference DAC Controller

This block sits behind a simple register bus and drives up to four output DAC channels plus a pair of reference DACs. Software writes a 16-bit setting to a channel's address; the controller accepts it, marks that channel busy and, after a fixed transfer time, presents the word on the channel's output with a one-cycle load strobe. A write that arrives while the channel is still transferring is held in a one-deep slot and started as soon as the current transfer ends.

The reference DACs are driven by a command word. It names the positive or the negative reference and starts an update that has its own busy flag. Software sets the positive reference first, waits for the busy flag to drop, and then does the same for the negative one. A single control address decodes two kinds of write: global bits (enable, signed data format, discard queued writes) and per-channel enable/disable codes. A read from the same address returns a status word that collects all busy and queue flags.

Top module: `dac_ref_ctrl`

## Requirements
- R1: After reset the status word reads 0, no load strobe is active, all channels are disabled and the global enable is off.
- R2: A write to address 0x38+2x is accepted when global enable and channel x's enable are both on. Status bit 4+x then reads 1 from the cycle after the write edge. It stays 1 for XFER_CYC (32) cycles.
- R3: When a transfer completes, status bit 4+x drops. dac_load[x] pulses high for one cycle, and dac_word[16x+15:16x] holds the transferred word from then on.
- R4: With the signed-format control bit (bit 1) set when the write is accepted, the transferred word is the written value with bit 15 inverted. With the bit clear, the word is unchanged.
- R5: A setting write to a disabled channel, or any setting write while global enable is off, is ignored: no busy flag, no load strobe.
- R6: At control address 0x20, a value whose bits 6:4 are 0 sets global enable (bit 0) and signed format (bit 1). The value 0x20+(x<<4) disables channel x and 0x21+(x<<4) enables it. Any other value, such as 0x60 or 0x61, changes nothing.
- R7: A setting write while channel x is busy is queued, and status bit 0 reads 1 while any write is queued. The queued write starts at the completion edge, so busy stays high. A later write replaces the queued one.
- R8: A control write with bits 6:4 equal to 0 and bit 2 set discards every queued write. Only the transfers already running complete.
- R9: A write to 0x2C with bit 7 set starts a reference update of REF_CYC (16) cycles, shown on status bit 1. At completion ref_load pulses for one cycle, and ref_pos reports bit 8 of the command (1 for positive, 0 for negative).
- R10: A reference command with bit 7 clear, or one issued while the reference update is busy, is ignored.
- R11: rdata returns the status word when rd_addr is 0x20 and 0 for any other address. Status bits 2, 3 and 15:8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Write address |
| wdata | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rdata | output | 16 | Read data (status at 0x20) |
| dac_load | output | 4 | Per-channel completion strobe |
| dac_word | output | 64 | Per-channel transferred words, 16 bits each |
| ref_load | output | 1 | Reference update completion strobe |
| ref_pos | output | 1 | Reference polarity of the completed update |

## Verification
Several rules are checked on every cycle. An accepted setting write raises its channel's busy flag. A write to an idle but disabled channel leaves the flag low. No busy flag, channel or reference, falls without its load strobe. The reference busy flag only rises after a command carrying the start bit. Other behaviour shows only in the bench's scenarios: the exact 32- and 16-cycle transfer lengths, the word values under each data format, replacement of a queued write, its discard by the control bit, and the positive-then-negative reference sequence.

// File: rtl/dac_ref_ctrl.sv
module dac_ref_ctrl #(
  parameter int NCH      = 4,
  parameter int XFER_CYC = 32,
  parameter int REF_CYC  = 16,
  parameter int AW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [15:0]       wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [15:0]       rdata,
  output logic [NCH-1:0]    dac_load,
  output logic [16*NCH-1:0] dac_word,
  output logic              ref_load,
  output logic              ref_pos
);
  localparam int CW = $clog2(XFER_CYC + 1);
  localparam int RW = $clog2(REF_CYC + 1);
  localparam logic [AW-1:0] A_CTL = AW'(8'h20);
  localparam logic [AW-1:0] A_REF = AW'(8'h2C);
  localparam int A_SET = 'h38;

  logic           ctl_en, sgn_fmt;
  logic [NCH-1:0] ch_en, busy, pend_v;
  logic [RW-1:0]  ref_cnt;
  logic           ref_sel;
  logic [15:0]    status;

  wire       ctl_wr = wr_en && addr == A_CTL;
  wire [2:0] grp    = wdata[6:4];
  wire       gbl_wr = ctl_wr && grp == 3'd0;
  wire       flush  = gbl_wr && wdata[2];
  wire [15:0] wv    = sgn_fmt ? (wdata ^ 16'h8000) : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      sgn_fmt <= 1'b0;
      ch_en   <= '0;
    end else if (ctl_wr) begin
      if (gbl_wr) begin
        ctl_en  <= wdata[0];
        sgn_fmt <= wdata[1];
      end
      for (int x = 0; x < NCH; x++)
        if (grp == 3'(x + 2)) ch_en[x] <= wdata[0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] cnt;
    logic [15:0]   cur, nxt, word;
    logic          pend, load;
    wire hit = wr_en && addr == AW'(A_SET + 2 * g) && ctl_en && ch_en[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        cur  <= '0;
        nxt  <= '0;
        word <= '0;
        pend <= 1'b0;
        load <= 1'b0;
      end else begin
        load <= 1'b0;
        if (cnt == '0) begin
          if (hit) begin
            cnt <= CW'(XFER_CYC);
            cur <= wv;
          end
        end else if (cnt == CW'(1)) begin
          load <= 1'b1;
          word <= cur;
          if (pend) begin
            cnt  <= CW'(XFER_CYC);
            cur  <= nxt;
            pend <= hit;
            if (hit) nxt <= wv;
          end else if (hit) begin
            cnt <= CW'(XFER_CYC);
            cur <= wv;
          end else begin
            cnt <= '0;
          end
        end else begin
          cnt <= cnt - CW'(1);
          if (hit) begin
            pend <= 1'b1;
            nxt  <= wv;
          end
        end
        if (flush) pend <= 1'b0;
      end
    end

    assign busy[g]              = cnt != '0;
    assign pend_v[g]            = pend;
    assign dac_load[g]          = load;
    assign dac_word[16*g +: 16] = word;
  end

  wire ref_go = wr_en && addr == A_REF && wdata[7] && ref_cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_sel  <= 1'b0;
      ref_load <= 1'b0;
      ref_pos  <= 1'b0;
    end else begin
      ref_load <= 1'b0;
      if (ref_go) begin
        ref_cnt <= RW'(REF_CYC);
        ref_sel <= wdata[8];
      end else if (ref_cnt == RW'(1)) begin
        ref_cnt  <= '0;
        ref_load <= 1'b1;
        ref_pos  <= ref_sel;
      end else if (ref_cnt != '0) begin
        ref_cnt <= ref_cnt - RW'(1);
      end
    end
  end

  always_comb begin
    status             = '0;
    status[0]          = |pend_v;
    status[1]          = ref_cnt != '0;
    status[4 +: NCH]   = busy;
  end

  assign rdata = (rd_addr == A_CTL) ? status : 16'h0000;
endmodule

// File: rtl/dac_ref_ctrl_chk.sv
module dac_ref_ctrl_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [15:0]    wdata,
  input logic [15:0]    status,
  input logic [NCH-1:0] dac_load,
  input logic           ref_load,
  input logic [NCH-1:0] ch_on
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    wire set_wr = wr_en && addr == AW'(8'h38 + 2 * g);

    AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr && ch_on[g] |=> status[4+g]); // R2
    AST_BUSY_FALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[4+g]) |-> dac_load[g]); // R3
    AST_OFF_CHANNEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr && !ch_on[g] && !status[4+g] |=> !status[4+g]); // R5
  end

  AST_REF_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(wr_en && addr == AW'(8'h2C) && wdata[7])); // R9
  AST_REF_FALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> ref_load); // R9
endmodule

bind dac_ref_ctrl dac_ref_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .status(status), .dac_load(dac_load), .ref_load(ref_load),
  .ch_on(ch_en & {NCH{ctl_en}})
);

// File: tb/dac_ref_ctrl_bench.sv
module dac_ref_ctrl_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0, rd_addr = 8'h20;
  logic [15:0] wdata = 0, rdata;
  logic [3:0]  dac_load;
  logic [63:0] dac_word;
  logic        ref_load, ref_pos;
  int total = 0, bad = 0;
  int lc [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  dac_ref_ctrl u_dac_ref_ctrl (.clk, .rst_n, .wr_en, .addr, .wdata, .rd_addr,
    .rdata, .dac_load, .dac_word, .ref_load, .ref_pos);

  always @(posedge clk) for (int i = 0; i < 4; i++) if (dac_load[i]) lc[i]++;

  // {channel, signed flag, written value, expected word}
  localparam logic [39:0] VEC [6] = '{
    {4'd0, 4'd0, 16'h1234, 16'h1234},
    {4'd1, 4'd1, 16'h0000, 16'h8000},
    {4'd2, 4'd1, 16'hFFFF, 16'h7FFF},
    {4'd3, 4'd0, 16'h8001, 16'h8001},
    {4'd0, 4'd1, 16'h7FFF, 16'hFFFF},
    {4'd3, 4'd1, 16'h8000, 16'h0000}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] w(input int c);
    return dac_word[16*c +: 16];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    wait_n(3); rst_n = 1; wait_n(1);
    chk(rdata == 0, "R1 status", rdata, 0);
    chk(dac_load == 0 && !ref_load, "R1 strobes", dac_load, 0);
    wr(8'h39, 16'h0011); wait_n(1);
    chk(rdata == 0, "R1 idle before enable", rdata, 0);

    for (int x = 0; x < 4; x++) wr(8'h20, 16'(16'h21 + (x << 4)));
    for (int v = 0; v < 6; v++) begin
      int ch;
      ch = int'(VEC[v][39:36]);
      wr(8'h20, {14'd0, VEC[v][32], 1'b1});
      wr(8'(8'h38 + 2 * ch), VEC[v][31:16]);
      chk(rdata[4+ch] == 1'b1, "R2 busy on write", rdata, 16'(1 << (4 + ch)));
      wait_n(31);
      chk(rdata[4+ch] == 1'b1, "R2 busy held", rdata, 16'(1 << (4 + ch)));
      wait_n(1);
      chk(rdata == 0 && dac_load[ch], "R3 completion", {dac_load, rdata[11:0]}, 0);
      chk(w(ch) == VEC[v][15:0], "R4 word format", w(ch), VEC[v][15:0]);
      wait_n(1);
      chk(dac_load == 0, "R3 single pulse", dac_load, 0);
    end

    // R6: pattern code ignored, signed format kept
    wr(8'h20, 16'h0003); wr(8'h20, 16'h0061);
    wr(8'h38, 16'h0001); wait_n(32);
    chk(w(0) == 16'h8001, "R6 pattern code ignored", w(0), 16'h8001);

    // R5: disabled channel and global disable
    wr(8'h20, 16'h0030); c0 = lc[1];
    wr(8'h3A, 16'h5555); wait_n(1);
    chk(rdata[5] == 0, "R5 disabled channel no busy", rdata, 0);
    wait_n(40);
    chk(lc[1] == c0, "R5 disabled channel no load", lc[1], c0);
    wr(8'h20, 16'h0031); wr(8'h20, 16'h0000);
    wr(8'h38, 16'h4444); wait_n(1);
    chk(rdata == 0, "R5 global disable", rdata, 0);

    // R7: queued write, newest replaces
    wr(8'h20, 16'h0001);
    wr(8'h3C, 16'hA000); wr(8'h3C, 16'hB000); wr(8'h3C, 16'hC000);
    chk(rdata[0] == 1'b1, "R7 queue flag", rdata, 16'h0041);
    wait_n(28);
    chk(dac_load[2] && w(2) == 16'hA000 && rdata[6], "R7 first done, still busy", w(2), 16'hA000);
    chk(rdata[0] == 0, "R7 queue drained", rdata, 16'h0040);
    wait_n(31);
    chk(rdata[6] == 1'b1, "R7 second transfer busy", rdata, 16'h0040);
    wait_n(1);
    chk(dac_load[2] && w(2) == 16'hC000, "R7 replaced value", w(2), 16'hC000);

    // R8: discard queued write
    c0 = lc[1];
    wr(8'h3A, 16'h1111); wr(8'h3A, 16'h2222);
    wr(8'h20, 16'h0005); wait_n(1);
    chk(rdata[0] == 0 && rdata[5], "R8 queue discarded", rdata, 16'h0020);
    wait_n(70);
    chk(lc[1] == c0 + 1 && w(1) == 16'h1111, "R8 one transfer only", lc[1], c0 + 1);

    // R11: read decode and reserved bits
    wr(8'h3E, 16'h0F0F); wait_n(1);
    chk(rdata[15:8] == 0 && rdata[3:2] == 0 && rdata[7], "R11 reserved zero", rdata, 16'h0080);
    rd_addr = 8'h38; #1;
    chk(rdata == 0, "R11 other address", rdata, 0);
    rd_addr = 8'h20; wait_n(40);

    // R9/R10: reference sequence
    wr(8'h2C, 16'h0100);
    wait_n(1);
    chk(rdata[1] == 0, "R10 no start bit", rdata, 0);
    wr(8'h2C, 16'h0180);
    chk(rdata[1] == 1'b1, "R9 positive busy", rdata, 16'h0002);
    wr(8'h2C, 16'h0080);
    wait_n(13);
    chk(rdata[1] == 1'b1, "R10 busy held", rdata, 16'h0002);
    wait_n(1);
    chk(ref_load && ref_pos && rdata[1] == 0, "R9 positive done", {ref_load, ref_pos}, 3);
    wr(8'h2C, 16'h0080);
    wait_n(15);
    chk(rdata[1] == 1'b1, "R9 negative busy", rdata, 16'h0002);
    wait_n(1);
    chk(ref_load && !ref_pos, "R9 negative done", {ref_load, ref_pos}, 2);
    wait_n(1);
    chk(!ref_load, "R9 single pulse", ref_load, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule